// File: doc/BRIEF.md
# Test Pulse Gating Ring with Column Fan-out

This block fans a digital and an analog test pulse out to every double column of a pixel array. The array is cut into regions of sixteen double columns each. Every region owns a gating register with one bit per double column, and a set bit lets both test pulses through to that column. A cleared bit holds both of them off. The gated outputs are plain combinational ANDs of the two pulse inputs with the current gating bits.

The regions are linked into rings. Inside a ring, bit 15 of one region feeds bit 0 of the next region, and the last region of the ring feeds the first. With the default parameters there are two rings of sixteen regions, so each ring is 256 bits long. When the rotate enable is high, the falling edge of either pulse input produces a single shift event. That event moves every ring forward by one bit. Successive pulses therefore reach different column sets without any new register writes. Software writes a region register through a simple write port and can read any region back combinationally, which lets it check the pattern after any number of rotations.

Top module: `pulse_gate_fanout`

## Requirements
- R1: Output bit `r*16+k` of `dpulse_o` equals `dpulse_i` AND bit k of region r's gating register. `apulse_o` is formed the same way from `apulse_i`, with no register stage.
- R2: While reset is asserted, and after it is released, every gating bit reads zero and no output pulses until a write sets a bit.
- R3: A write with `wr_en_i` high loads `wr_data_i` into region `wr_region_i` at the clock edge. The new value appears on `rd_data_o` in the next cycle.
- R4: A shift event happens in a cycle where `rot_en_i` is high and at least one pulse input is low after being high in the previous cycle. At that edge, every bit k>0 of each region takes the old bit k-1, and bit 0 takes bit 15 of the previous region in the ring.
- R5: Region 0 bit 0 takes region 15 bit 15, and region 16 bit 0 takes region 31 bit 15. No bit crosses between the two rings.
- R6: While `rot_en_i` is low, the end of a pulse leaves every gating register unchanged.
- R7: When a write and a shift event fall in the same cycle, the written region takes the written value. Every other region shifts, and the next region in the ring takes the written region's pre-write bit 15.
- R8: A pulse held high for several cycles gives exactly one shift, at its trailing edge, and no shift at its rising edge. Two pulses ending in the same cycle also give one shift.
- R9: `rd_data_o` always shows the current gating register of region `rd_region_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dpulse_i | input | 1 | Digital test pulse from the central source |
| apulse_i | input | 1 | Analog test pulse from the central source |
| rot_en_i | input | 1 | Enables rotation on pulse trailing edges |
| wr_en_i | input | 1 | Gating register write strobe |
| wr_region_i | input | 5 | Region selected for the write |
| wr_data_i | input | 16 | Gating pattern to write |
| rd_region_i | input | 5 | Region selected for read-back |
| rd_data_o | output | 16 | Gating pattern of the selected region |
| dpulse_o | output | 512 | Gated digital pulse, one bit per double column |
| apulse_o | output | 512 | Gated analog pulse, one bit per double column |

## Verification
The bench builds the block with its default parameters: two rings of sixteen regions with sixteen columns each. This keeps both ring wrap points and the boundary between the rings within reach of short directed sequences. Random pulse trains mix long and short pulses, overlapping digital and analog pulses, and writes that collide with shift events. Repeated rotations therefore carry single set bits across many region boundaries, and the full 512-bit outputs are compared on every cycle.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  localparam int unsigned PGF_RINGS      = 2;
  localparam int unsigned PGF_RING_LEN   = 16;
  localparam int unsigned PGF_COLS       = 16;

  // index of the region feeding region r within its ring
  function automatic int unsigned pgf_feeder(int unsigned r, int unsigned ring_len);
    if ((r % ring_len) == 0) return r + ring_len - 1;
    return r - 1;
  endfunction
endpackage

// File: rtl/pgf_rst_sync.sv
module pgf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pgf_edge_detect.sv
module pgf_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dpulse_i,
  input  logic apulse_i,
  input  logic rot_en_i,
  output logic shift_o
);
  logic dpulse_q, apulse_q;
  logic dpulse_d, apulse_d;
  logic d_fall, a_fall;

  always_comb begin
    dpulse_d = dpulse_i;
    apulse_d = apulse_i;
    d_fall   = dpulse_q & ~dpulse_i;
    a_fall   = apulse_q & ~apulse_i;
    shift_o  = rot_en_i & (d_fall | a_fall);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpulse_q <= 1'b0;
      apulse_q <= 1'b0;
    end else begin
      dpulse_q <= dpulse_d;
      apulse_q <= apulse_d;
    end
  end
endmodule

// File: rtl/pgf_region_reg.sv
module pgf_region_reg #(
  parameter int unsigned COLS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [COLS-1:0] load_data_i,
  input  logic            shift_i,
  input  logic            shift_in_i,
  output logic [COLS-1:0] mask_o
);
  logic [COLS-1:0] mask_q, mask_d;
  logic            mask_en;

  always_comb begin
    mask_en = load_i | shift_i;
    if (load_i) mask_d = load_data_i;
    else        mask_d = {mask_q[COLS-2:0], shift_in_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/pgf_fanout.sv
module pgf_fanout #(
  parameter int unsigned NCOL = 512
) (
  input  logic [NCOL-1:0] gate_i,
  input  logic            dpulse_i,
  input  logic            apulse_i,
  output logic [NCOL-1:0] dpulse_o,
  output logic [NCOL-1:0] apulse_o
);
  always_comb begin
    dpulse_o = gate_i & {NCOL{dpulse_i}};
    apulse_o = gate_i & {NCOL{apulse_i}};
  end
endmodule

// File: rtl/pulse_gate_fanout.sv
module pulse_gate_fanout #(
  parameter int unsigned RINGS    = pgf_pkg::PGF_RINGS,
  parameter int unsigned RING_LEN = pgf_pkg::PGF_RING_LEN,
  parameter int unsigned COLS     = pgf_pkg::PGF_COLS,
  localparam int unsigned NREG    = RINGS * RING_LEN,
  localparam int unsigned RW      = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned NCOL    = NREG * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dpulse_i,
  input  logic            apulse_i,
  input  logic            rot_en_i,
  input  logic            wr_en_i,
  input  logic [RW-1:0]   wr_region_i,
  input  logic [COLS-1:0] wr_data_i,
  input  logic [RW-1:0]   rd_region_i,
  output logic [COLS-1:0] rd_data_o,
  output logic [NCOL-1:0] dpulse_o,
  output logic [NCOL-1:0] apulse_o
);
  logic            rst_sync_n;
  logic            shift;
  logic [NCOL-1:0] gate_flat;
  logic [COLS-1:0] mask   [NREG];
  logic [NREG-1:0] load_sel;

  pgf_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  pgf_edge_detect i_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .dpulse_i (dpulse_i),
    .apulse_i (apulse_i),
    .rot_en_i (rot_en_i),
    .shift_o  (shift)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_region
    localparam int unsigned FEED = pgf_pkg::pgf_feeder(r, RING_LEN);

    assign load_sel[r] = wr_en_i && (wr_region_i == RW'(r));

    pgf_region_reg #(.COLS(COLS)) i_reg (
      .clk_i       (clk_i),
      .rst_ni      (rst_sync_n),
      .load_i      (load_sel[r]),
      .load_data_i (wr_data_i),
      .shift_i     (shift),
      .shift_in_i  (mask[FEED][COLS-1]),
      .mask_o      (mask[r])
    );

    assign gate_flat[r*COLS +: COLS] = mask[r];
  end

  always_comb begin
    rd_data_o = '0;
    for (int unsigned r = 0; r < NREG; r++) begin
      if (rd_region_i == RW'(r)) rd_data_o = mask[r];
    end
  end

  pgf_fanout #(.NCOL(NCOL)) i_fanout (
    .gate_i   (gate_flat),
    .dpulse_i (dpulse_i),
    .apulse_i (apulse_i),
    .dpulse_o (dpulse_o),
    .apulse_o (apulse_o)
  );
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
  parameter int unsigned RINGS    = 2,
  parameter int unsigned RING_LEN = 16,
  parameter int unsigned COLS     = 16,
  localparam int unsigned NREG    = RINGS * RING_LEN,
  localparam int unsigned RW      = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned NCOL    = NREG * COLS,
  localparam int unsigned RBITS   = RING_LEN * COLS
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            dpulse_i,
  input logic            apulse_i,
  input logic            rot_en_i,
  input logic            wr_en_i,
  input logic [RW-1:0]   wr_region_i,
  input logic [COLS-1:0] wr_data_i,
  input logic            shift,
  input logic [NCOL-1:0] gate_flat,
  input logic [NCOL-1:0] dpulse_o,
  input logic [NCOL-1:0] apulse_o
);
  logic [RW-1:0]   last_reg_q;
  logic [COLS-1:0] last_dat_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      last_reg_q <= '0;
      last_dat_q <= '0;
    end else begin
      last_reg_q <= wr_region_i;
      last_dat_q <= wr_data_i;
    end
  end

  function automatic logic [NCOL-1:0] ring_step(logic [NCOL-1:0] v);
    logic [NCOL-1:0] res;
    for (int unsigned g = 0; g < RINGS; g++) begin
      for (int unsigned i = 0; i < RBITS; i++) begin
        res[g*RBITS + i] = v[g*RBITS + ((i == 0) ? RBITS - 1 : i - 1)];
      end
    end
    return res;
  endfunction

  // R1
  idle_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!dpulse_i && !apulse_i) |-> (dpulse_o == '0 && apulse_o == '0));
  // R1
  dgate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    dpulse_i |-> (dpulse_o == gate_flat));
  // R1
  agate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    apulse_i |-> (apulse_o == gate_flat));
  // R3
  write_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i |=> (gate_flat[last_reg_q*COLS +: COLS] == last_dat_q));
  // R4
  rot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (shift && !wr_en_i) |=> (gate_flat == ring_step($past(gate_flat))));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rot_en_i && !wr_en_i) |=> $stable(gate_flat));
  // R8
  shift_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    shift |-> (rot_en_i && !(dpulse_i && apulse_i)));
endmodule

bind pulse_gate_fanout pgf_checker #(
  .RINGS(RINGS), .RING_LEN(RING_LEN), .COLS(COLS)
) i_pgf_checker (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .dpulse_i    (dpulse_i),
  .apulse_i    (apulse_i),
  .rot_en_i    (rot_en_i),
  .wr_en_i     (wr_en_i),
  .wr_region_i (wr_region_i),
  .wr_data_i   (wr_data_i),
  .shift       (shift),
  .gate_flat   (gate_flat),
  .dpulse_o    (dpulse_o),
  .apulse_o    (apulse_o)
);

// File: tb/test_pulse_gate_fanout.sv
module test_pulse_gate_fanout;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int RLEN = 16;
  localparam int COLS = 16;
  localparam int NCOL = NREG * COLS;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            dpulse_i, apulse_i, rot_en_i, wr_en_i;
  logic [4:0]      wr_region_i, rd_region_i;
  logic [15:0]     wr_data_i;
  logic [15:0]     rd_data_o;
  logic [NCOL-1:0] dpulse_o, apulse_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] m [NREG];
  bit md = 1'b0;
  bit ma = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pulse_gate_fanout i_pulse_gate_fanout (
    .clk_i(clk_i), .rst_ni(rst_ni), .dpulse_i(dpulse_i), .apulse_i(apulse_i),
    .rot_en_i(rot_en_i), .wr_en_i(wr_en_i), .wr_region_i(wr_region_i),
    .wr_data_i(wr_data_i), .rd_region_i(rd_region_i), .rd_data_o(rd_data_o),
    .dpulse_o(dpulse_o), .apulse_o(apulse_o)
  );

  function automatic int feeder(int r);
    return ((r % RLEN) == 0) ? r + RLEN - 1 : r - 1;
  endfunction

  function automatic logic [NCOL-1:0] exp_out(bit p);
    logic [NCOL-1:0] v = '0;
    for (int r = 0; r < NREG; r++) v[r*COLS +: COLS] = p ? m[r] : 16'h0;
    return v;
  endfunction

  function automatic void model_step(bit d, bit a, bit rot, bit we, int wreg, logic [15:0] wdat);
    logic [15:0] old [NREG];
    bit sh;
    sh = rot && ((md && !d) || (ma && !a));
    for (int r = 0; r < NREG; r++) old[r] = m[r];
    for (int r = 0; r < NREG; r++) begin
      if (we && wreg == r) m[r] = wdat;
      else if (sh)         m[r] = {old[r][14:0], old[feeder(r)][15]};
    end
    md = d;
    ma = a;
  endfunction

  task automatic chk_word(string tag, logic [NCOL-1:0] act, logic [NCOL-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(bit d, bit a, bit rot, bit we, int wreg, logic [15:0] wdat,
                       int rreg, string tag);
    dpulse_i = d; apulse_i = a; rot_en_i = rot; wr_en_i = we;
    wr_region_i = 5'(wreg); wr_data_i = wdat; rd_region_i = 5'(rreg);
    #1;
    chk_word({tag, " R9 read-back"}, NCOL'(rd_data_o), NCOL'(m[rreg]));
    chk_word({tag, " R1 digital out"}, dpulse_o, exp_out(d));
    chk_word({tag, " R1 analog out"}, apulse_o, exp_out(a));
    @(posedge clk_i);
    model_step(d, a, rot, we, wreg, wdat);
    @(negedge clk_i);
  endtask

  task automatic idle(int rreg, string tag);
    apply(0, 0, 1, 0, 0, 16'h0, rreg, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_9bdf));
    for (int r = 0; r < NREG; r++) m[r] = '0;
    rst_ni = 1'b0;
    dpulse_i = 0; apulse_i = 0; rot_en_i = 0; wr_en_i = 0;
    wr_region_i = '0; wr_data_i = '0; rd_region_i = '0;
    repeat (3) @(negedge clk_i);
    // R2: outputs dark and registers clear while in reset
    chk_word("R2 in reset", NCOL'(rd_data_o), '0);
    rst_ni = 1'b1;
    repeat (4) apply(0, 0, 0, 0, 0, 16'h0, 0, "R2 settle");
    for (int r = 0; r < NREG; r++) apply(1, 1, 0, 0, 0, 16'h0, r, "R2 cleared");
    apply(0, 0, 0, 0, 0, 16'h0, 0, "R2 idle");

    // R3: write then read back
    apply(0, 0, 0, 1, 5, 16'h8001, 5, "R3 write");
    idle(5, "R3 readback");
    apply(1, 0, 0, 0, 0, 16'h0, 5, "R3 gated");

    // R5: ring wrap points and ring separation
    apply(0, 0, 0, 1, 5, 16'h0000, 0, "R5 clear");
    apply(0, 0, 0, 1, 15, 16'h8000, 0, "R5 load15");
    apply(0, 0, 0, 1, 31, 16'h8000, 0, "R5 load31");
    // R8: long pulse, one shift at the trailing edge only
    apply(0, 1, 1, 0, 0, 16'h0, 15, "R8 rise");
    apply(0, 1, 1, 0, 0, 16'h0, 15, "R8 hold");
    apply(0, 1, 1, 0, 0, 16'h0, 15, "R8 hold");
    apply(0, 0, 1, 0, 0, 16'h0, 0, "R8 fall");
    idle(0, "R5 ring0 wrap");
    idle(16, "R5 ring1 wrap");
    idle(15, "R5 source empty");

    // R4: both pulses ending together give one shift
    apply(1, 1, 1, 0, 0, 16'h0, 0, "R4 both high");
    apply(0, 0, 1, 0, 0, 16'h0, 0, "R4 both fall");
    idle(0, "R4 single step");

    // R6: rotation disabled
    apply(1, 0, 0, 0, 0, 16'h0, 0, "R6 pulse");
    apply(0, 0, 0, 0, 0, 16'h0, 0, "R6 fall");
    idle(0, "R6 unchanged");

    // R7: write collides with shift
    apply(0, 0, 0, 1, 3, 16'h8000, 3, "R7 preload");
    apply(1, 0, 1, 0, 0, 16'h0, 3, "R7 pulse");
    apply(0, 0, 1, 1, 3, 16'h1234, 4, "R7 collide");
    idle(3, "R7 write wins");
    idle(4, "R7 neighbour old bit");

    // R4 R1: constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit d, a, rot, we;
      d   = ($urandom_range(0, 99) < 35);
      a   = ($urandom_range(0, 99) < 25);
      rot = ($urandom_range(0, 99) < 80);
      we  = ($urandom_range(0, 99) < 12);
      apply(d, a, rot, we, $urandom_range(0, NREG-1), 16'($urandom()),
            $urandom_range(0, NREG-1), "R4 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule